// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent page-map entries. Each entry pairs a virtual page number (the tag) with a physical page number and a dirty flag. A lookup compares the presented virtual page number against every valid entry at once. On a hit, the block returns the physical page number and dirty flag in the same cycle, so no page-map read goes to main memory. On a miss, it raises a miss flag so that an external page-map walker can fetch the entry.

The walker returns its result through a fill port. A fill whose resident flag is set is installed in the cache. The block first reuses the slot that already holds the same virtual page. If there is none, it takes the lowest-numbered empty slot. If every slot is full, it evicts the slot named by a round-robin pointer. A fill whose resident flag is clear is not stored; instead the block raises a one-cycle fault. A flush input clears every entry when the address-space context changes.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, every lookup misses and `fault` is low.
- R2: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high in the same cycle. On a hit, `lk_ppn` and `lk_dirty` are the values stored with the matching tag. While `lk_valid` is low, both flags are low.
- R3: A fill with `fill_resident` set is written at the clock edge that ends its cycle. A lookup of the same page in the fill cycle misses, and lookups hit from the next cycle on.
- R4: While at least one entry is invalid, a fill of a new page writes the lowest-indexed invalid entry and evicts no valid entry.
- R5: When all entries are valid, a fill of a new page replaces the entry named by a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping modulo the entry count, after each such replacement only.
- R6: A fill of a page that is already cached overwrites that entry's physical page number and dirty flag. No other entry changes, and the round-robin pointer does not move.
- R7: A fill with `fill_resident` clear stores nothing and moves no pointer. It makes `fault` high for exactly the one cycle that follows the fill.
- R8: `flush` invalidates every entry and returns the round-robin pointer to entry 0 at the next edge. A lookup in the flush cycle itself misses.
- R9: When `flush` and a fill occur in the same cycle, the flush wins and the fill is dropped.
- R10: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries (context change) |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_miss | output | 1 | Lookup found no entry; a page-map walk is needed |
| lk_ppn | output | PPN_W | Physical page number on a hit, zero otherwise |
| lk_dirty | output | 1 | Dirty flag on a hit, zero otherwise |
| fill_valid | input | 1 | Walker result presented this cycle |
| fill_vpn | input | VPN_W | Virtual page number of the walked entry |
| fill_ppn | input | PPN_W | Physical page number of the walked entry |
| fill_dirty | input | 1 | Dirty flag of the walked entry |
| fill_resident | input | 1 | Page is in physical memory; clear means fault |
| fault | output | 1 | One-cycle pulse after a non-resident fill |

## Verification
The bench steps the round-robin pointer through several replacements. It then checks that refilling a page that is already cached moves neither the pointer nor any other entry. A design that allocated a fresh slot for that refill would leave a stale duplicate behind, and its later evictions would hit the wrong slot. The bench also presents a lookup and a fill of the same page in one cycle and expects a miss. A design that forwarded the fill data would report an early hit. Further cases are a non-resident fill, a flush while a lookup is in progress, and a flush together with a fill. A design that got these wrong would take a victim slot for the faulting fill, leak a hit out of a flushed cache, or install a mapping from the old context.

// File: rtl/xlat_pkg.sv
// Package: shared types for the translation cache.
// Assumes: nothing beyond the standard language.
package xlat_pkg;

    // How a fill is placed into the entry store.
    typedef enum logic [1:0] {
        PLACE_NONE   = 2'd0,  // nothing written
        PLACE_UPDATE = 2'd1,  // overwrite the entry already holding the page
        PLACE_FREE   = 2'd2,  // write the lowest invalid entry
        PLACE_EVICT  = 2'd3   // replace the round-robin victim
    } place_e;

endpackage

// File: rtl/xlat_tag_match.sv
// Module: parallel tag comparator.
// Compares one key against all valid tags and encodes the matching index.
// Assumes: at most one entry matches (the top guarantees unique tags).
module xlat_tag_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    // Encode the matching entry into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;

endmodule

// File: rtl/xlat_victim.sv
// Module: replacement selector.
// Picks the lowest invalid entry, or the round-robin pointer when all are valid.
// Assumes: advance is raised only for a replacement made while all entries are valid.
module xlat_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               advance,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   sel,
    output logic               full
);

    logic [IDX_W-1:0] rr_ptr;

    assign full = &valid;

    // Lowest invalid entry wins, otherwise the round-robin pointer.
    always_comb begin
        sel = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) sel = IDX_W'(i);
        end
    end

    // Round-robin pointer: reset and flush return it to entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  rr_ptr <= '0;
        else if (advance)     rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end

    // R4: while not full, the selected slot is an empty one.
    p_free_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !valid[sel]);

    // R5: the pointer wraps to zero after the last entry.
    p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !flush && rr_ptr == LAST) |=> (rr_ptr == '0));

    // R5: the pointer holds still when there is no replacement.
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !flush) |=> $stable(rr_ptr));

endmodule

// File: rtl/xlat_entry_store.sv
// Module: entry registers (valid, tag, physical page, dirty).
// One write port; flush clears every valid bit and overrides the write.
// Assumes: the write index is supplied already resolved by the top.
module xlat_entry_store #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  logic [VPN_W-1:0]              wtag,
    input  logic [PPN_W-1:0]              wppn,
    input  logic                          wdirty,
    output logic [ENTRIES-1:0]            valid,
    output logic [ENTRIES-1:0][VPN_W-1:0] tags,
    output logic [ENTRIES-1:0][PPN_W-1:0] ppns,
    output logic [ENTRIES-1:0]            dirty
);

    // Per-entry state, one register group per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic hit_w;
        assign hit_w = we && (widx == IDX_W'(g));

        // Valid bit: cleared by reset or flush, set by a write.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) valid[g] <= 1'b0;
            else if (hit_w)      valid[g] <= 1'b1;
        end

        // Payload: loaded on a write, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[g]  <= '0;
                ppns[g]  <= '0;
                dirty[g] <= 1'b0;
            end else if (hit_w && !flush) begin
                tags[g]  <= wtag;
                ppns[g]  <= wppn;
                dirty[g] <= wdirty;
            end
        end
    end

    // R8: a flush leaves no valid entry.
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid == '0));

    // R3: a write makes its slot valid at the next edge.
    p_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !flush) |=> valid[$past(widx)]);

endmodule

// File: rtl/xlat_cache.sv
// Module: fully associative address translation cache (top).
// Lookup is combinational against the current registers; fills land at the edge.
// Assumes: the walker presents one fill per cycle at most.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_dirty,
    input  logic             fill_resident,
    output logic             fault
);

    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_tags;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppns;
    logic [ENTRIES-1:0]            ent_dirty;

    logic [ENTRIES-1:0] lk_match, fl_match;
    logic               lk_any, fl_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               all_full;
    place_e             place;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;

    xlat_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .we(wr_en), .widx(wr_idx), .wtag(fill_vpn), .wppn(fill_ppn), .wdirty(fill_dirty),
        .valid(ent_valid), .tags(ent_tags), .ppns(ent_ppns), .dirty(ent_dirty)
    );

    xlat_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid(ent_valid), .tags(ent_tags), .key(lk_vpn),
        .match(lk_match), .any(lk_any), .idx(lk_idx)
    );

    xlat_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_match (
        .valid(ent_valid), .tags(ent_tags), .key(fill_vpn),
        .match(fl_match), .any(fl_any), .idx(fl_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .advance(place == PLACE_EVICT), .valid(ent_valid),
        .sel(vic_idx), .full(all_full)
    );

    // Lookup result: a flush in progress suppresses any hit.
    always_comb begin
        lk_hit   = lk_valid && lk_any && !flush;
        lk_miss  = lk_valid && !lk_hit;
        lk_ppn   = lk_hit ? ent_ppns[lk_idx]  : '0;
        lk_dirty = lk_hit ? ent_dirty[lk_idx] : 1'b0;
    end

    // Fill placement: flush and non-resident fills write nothing.
    always_comb begin
        if (!fill_valid || flush || !fill_resident) place = PLACE_NONE;
        else if (fl_any)                            place = PLACE_UPDATE;
        else if (!all_full)                         place = PLACE_FREE;
        else                                        place = PLACE_EVICT;
    end

    assign wr_en  = (place != PLACE_NONE);
    assign wr_idx = (place == PLACE_UPDATE) ? fl_idx : vic_idx;

    // Fault pulse: registered one cycle after a non-resident fill.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= fill_valid && !fill_resident;
    end

    // R2: hit and miss are never both high, and both are low when idle.
    p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss) && (lk_valid || (!lk_hit && !lk_miss)));

    // R7: a non-resident fill yields a fault in the following cycle.
    p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_resident) |=> fault);

    // R7: a non-resident fill does not change the valid set.
    p_fault_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_resident && !flush) |=> $stable(ent_valid));

    // R8: no hit is reported during a flush cycle.
    p_flush_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !lk_hit);

    // R10: tags stay unique, so at most one entry matches any key.
    p_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fl_match));

endmodule

// File: tb/test_xlat_cache.sv
// Scoreboard bench: the driver queues expected lookup results, the monitor compares them.
module test_xlat_cache;

    localparam int VW = 20;
    localparam int PW = 18;

    typedef struct {
        logic [VW-1:0] vpn;
        bit            hit;
        logic [PW-1:0] ppn;
        bit            dirty;
        int            req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_hit, lk_miss, lk_dirty, fault;
    logic [PW-1:0] lk_ppn;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic          fill_dirty = 1'b0;
    logic          fill_resident = 1'b0;

    int   tests = 0;
    int   fails = 0;
    exp_t sb_q[$];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_dirty(fill_dirty), .fill_resident(fill_resident), .fault(fault)
    );

    // One cycle of stimulus; a lookup pushes its expected result.
    task automatic drive(input bit lv, input logic [VW-1:0] lvpn, input bit eh,
                         input logic [PW-1:0] ep, input bit ed, input int rq,
                         input bit fv, input logic [VW-1:0] fvpn, input logic [PW-1:0] fppn,
                         input bit fd, input bit fr, input bit fl);
        @(posedge clk); #1;
        lk_valid = lv;  lk_vpn = lvpn;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
        fill_dirty = fd; fill_resident = fr; flush = fl;
        if (lv) sb_q.push_back('{vpn: lvpn, hit: eh, ppn: ep, dirty: ed, req: rq});
    endtask

    task automatic look(input logic [VW-1:0] v, input bit eh, input logic [PW-1:0] ep,
                        input bit ed, input int rq);
        drive(1'b1, v, eh, ep, ed, rq, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input bit d, input bit r);
        drive(1'b0, '0, 1'b0, '0, 1'b0, 0, 1'b1, v, p, d, r, 1'b0);
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, '0, 1'b0, 0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    // Check the fault output in the current cycle.
    task automatic check_fault(input bit e, input int rq);
        @(negedge clk);
        tests++;
        if (fault !== e) begin
            fails++;
            $display("FAIL R%0d fault: actual %0b expected %0b", rq, fault, e);
        end
    endtask

    // Monitor: pops one expectation per lookup cycle, checks idle cycles too.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && lk_valid) begin
                exp_t e;
                tests++;
                if (sb_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 scoreboard empty: actual lookup expected none");
                end else begin
                    e = sb_q.pop_front();
                    if (lk_hit !== e.hit || lk_miss !== !e.hit ||
                        lk_ppn !== (e.hit ? e.ppn : '0) || lk_dirty !== (e.hit ? e.dirty : 1'b0)) begin
                        fails++;
                        $display("FAIL R%0d vpn %h: actual hit=%0b miss=%0b ppn=%h d=%0b expected hit=%0b ppn=%h d=%0b",
                                 e.req, e.vpn, lk_hit, lk_miss, lk_ppn, lk_dirty,
                                 e.hit, e.hit ? e.ppn : '0, e.hit ? e.dirty : 1'b0);
                    end
                end
            end else if (rst_n && !lk_valid) begin
                tests++;
                if (lk_hit !== 1'b0 || lk_miss !== 1'b0) begin
                    fails++;
                    $display("FAIL R2 idle flags: actual hit=%0b miss=%0b expected 0 0", lk_hit, lk_miss);
                end
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hang counts as one failed check.
    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset, no fault.
        look(20'h00100, 0, '0, 0, 1);
        check_fault(1'b0, 1);

        // R4, R2: fill eight pages into empty slots; none is evicted.
        for (int i = 0; i < 8; i++) fill(20'h00100 + VW'(i), 18'h00200 + PW'(i), i[0], 1'b1);
        for (int i = 0; i < 8; i++) look(20'h00100 + VW'(i), 1, 18'h00200 + PW'(i), i[0], 4);
        idle();

        // R5: the full cache evicts slot 0, then slot 1.
        fill(20'h00300, 18'h003AA, 1, 1);
        look(20'h00100, 0, '0, 0, 5);
        look(20'h00300, 1, 18'h003AA, 1, 5);
        look(20'h00101, 1, 18'h00201, 1, 5);
        fill(20'h00301, 18'h003AB, 0, 1);
        look(20'h00101, 0, '0, 0, 5);
        look(20'h00102, 1, 18'h00202, 0, 5);

        // R6: a refill updates in place; others intact; pointer still at slot 2.
        fill(20'h00102, 18'h00111, 1, 1);
        look(20'h00102, 1, 18'h00111, 1, 6);
        for (int i = 3; i < 8; i++) look(20'h00100 + VW'(i), 1, 18'h00200 + PW'(i), i[0], 6);
        look(20'h00301, 1, 18'h003AB, 0, 6);
        fill(20'h00302, 18'h003AC, 0, 1);
        look(20'h00102, 0, '0, 0, 6);
        look(20'h00103, 1, 18'h00203, 1, 6);
        look(20'h00302, 1, 18'h003AC, 0, 10);

        // R3: a lookup in the fill cycle misses, then hits.
        drive(1'b1, 20'h00303, 1'b0, '0, 1'b0, 3, 1'b1, 20'h00303, 18'h003AD, 1'b1, 1'b1, 1'b0);
        look(20'h00303, 1, 18'h003AD, 1, 3);

        // R7: a non-resident fill faults for one cycle and stores nothing.
        fill(20'h00400, 18'h00999, 0, 0);
        look(20'h00400, 0, '0, 0, 7);
        check_fault(1'b1, 7);
        look(20'h00104, 1, 18'h00204, 0, 7);
        check_fault(1'b0, 7);
        fill(20'h00304, 18'h003AE, 0, 1);
        look(20'h00104, 0, '0, 0, 7);
        look(20'h00105, 1, 18'h00205, 1, 7);

        // R8: a lookup in the flush cycle misses; everything is gone afterwards.
        drive(1'b1, 20'h00105, 1'b0, '0, 1'b0, 8, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        look(20'h00105, 0, '0, 0, 8);
        look(20'h00300, 0, '0, 0, 8);

        // R8: the pointer restarts at slot 0 after the flush.
        for (int i = 0; i < 8; i++) fill(20'h00500 + VW'(i), 18'h00500 + PW'(i), 1'b0, 1'b1);
        fill(20'h00508, 18'h00508, 1, 1);
        look(20'h00500, 0, '0, 0, 8);
        look(20'h00501, 1, 18'h00501, 0, 8);
        look(20'h00508, 1, 18'h00508, 1, 8);

        // R9: a flush with a fill in the same cycle drops the fill.
        drive(1'b0, '0, 1'b0, '0, 1'b0, 0, 1'b1, 20'h00600, 18'h00600, 1'b0, 1'b1, 1'b1);
        look(20'h00600, 0, '0, 0, 9);
        look(20'h00501, 0, '0, 0, 9);
        idle();
        idle();

        if (sb_q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R2 scoreboard leftover: actual %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
    end

endmodule